// File: doc/BRIEF.md
# Latched-Request Interrupt Controller

This block gathers 32 interrupt request lines next to a processor core and presents them through two registers on a small register port. One register is the enable mask, and the other holds the pending requests. Every request line is captured into its own pending bit, and the bit stays set until software acknowledges it. This is true for lines sensed on a rising edge and for lines sensed by level. A level line therefore stays pending after its source lets go.

The core receives a single interrupt output. That output is the registered OR of all pending bits that are also enabled. Software reads the pending register and services the lowest set bit first. It then acknowledges that bit. A build-time parameter picks the acknowledge convention. In one mode, writing a one clears a bit. In the other mode, writing a zero clears a bit, so software writes back the value it read with only the serviced bit cleared. A second parameter vector chooses edge or level sensing for each line.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, the mask register reads 0, the pending register reads 0 and `core_irq` is 0.
- R2: A line configured for edge sensing (bit i of EDGE_SEL = 1; the default makes lines 0 to 15 edge lines) sets its pending bit on the clock edge where the line is 1 and was 0 at the previous edge. Holding the line high sets nothing further.
- R3: A level-sensed line (bit i of EDGE_SEL = 0; the default makes lines 16 to 31 level lines) sets its pending bit on every edge where the line is 1. The bit stays set after the line returns to 0.
- R4: With ACK_MODE = ACK_WRITE_ONE, a write to the pending register clears each bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged.
- R5: With ACK_MODE = ACK_WRITE_ZERO, a write to the pending register clears each bit whose data bit is 0 and leaves each bit whose data bit is 1 unchanged.
- R6: If a line requests in the same cycle that its pending bit is written with a clearing value, the bit ends up set.
- R7: A write to the mask register (reg_sel = 0) stores the data, and later reads return it. Reads of the pending register (reg_sel = 1) return the raw pending bits whatever the mask holds.
- R8: `core_irq` is 1 in the cycle after any bit that is both pending and enabled exists, and 0 in the cycle after none does. A line whose mask bit is 0 never raises it.
- R9: Without a write to the pending register, no pending bit ever goes from 1 to 0.
- R10: A write to one register leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 32 | Interrupt request lines |
| reg_sel | input | 1 | Register select: 0 = mask, 1 = pending |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| core_irq | output | 1 | Interrupt request to the core |

## Verification
The hardest case to reach from the ports is a request and an acknowledge landing on the same bit in the same cycle. Random traffic seldom lines these up. A directed step holds a level line high while its bit is written with a clearing value. It then drops the line and reads the bit back. Two instances run side by side, one for each acknowledge mode, with independent write data. Long random stretches of sparse line activity, mask changes and partial acknowledges are compared every cycle against a reference model kept in the bench.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_PEND = 1'b1
  } irqc_sel_e;

  typedef enum logic {
    ACK_WRITE_ONE  = 1'b0,
    ACK_WRITE_ZERO = 1'b1
  } irqc_ack_e;

endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_o = stage_q[1];

endmodule

// File: rtl/irqc_sense.sv
module irqc_sense #(
  parameter int unsigned        LINES    = 32,
  parameter logic [LINES-1:0]   EDGE_SEL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] req_o
);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (EDGE_SEL[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
        end else begin
          prev_q <= line_i[i];
        end
      end
      assign req_o[i] = line_i[i] & ~prev_q;
    end else begin : g_level
      assign req_o[i] = line_i[i];
    end
  end

endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
  import irqc_pkg::*;
#(
  parameter int unsigned LINES    = 32,
  parameter irqc_ack_e   ACK_MODE = ACK_WRITE_ONE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_i,
  input  logic             ack_we_i,
  input  logic [LINES-1:0] ack_data_i,
  output logic [LINES-1:0] pend_o
);

  logic [LINES-1:0] pend_q, pend_d, clr_vec;
  logic             armed_q;

  if (ACK_MODE == ACK_WRITE_ONE) begin : g_ack_one
    assign clr_vec = ack_we_i ? ack_data_i : '0;
  end else begin : g_ack_zero
    assign clr_vec = ack_we_i ? ~ack_data_i : '0;
  end

  always_comb begin
    pend_d = (pend_q & ~clr_vec) | req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      armed_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;

  AST_REQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> ((pend_q & $past(req_i)) == $past(req_i))); // R6

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> ((pend_q & ~$past(pend_q) & ~$past(req_i)) == '0)); // R2

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !ack_we_i) |=> (($past(pend_q) & ~pend_q) == '0)); // R9

  if (ACK_MODE == ACK_WRITE_ONE) begin : g_chk_one
    AST_ACK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && ack_we_i) |=>
        ((pend_q & $past(ack_data_i) & ~$past(req_i)) == '0)); // R4
  end else begin : g_chk_zero
    AST_ACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && ack_we_i) |=>
        ((pend_q & ~$past(ack_data_i) & ~$past(req_i)) == '0)); // R5
  end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned      LINES    = 32,
  parameter logic [LINES-1:0] EDGE_SEL = 32'h0000_FFFF,
  parameter irqc_ack_e        ACK_MODE = ACK_WRITE_ONE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic             reg_sel,
  input  logic             reg_we,
  input  logic [LINES-1:0] reg_wdata,
  output logic [LINES-1:0] reg_rdata,
  output logic             core_irq
);

  logic             rst_n_s;
  logic [LINES-1:0] req, pend, mask_q, mask_d;
  logic             mask_we, pend_we;
  logic             irq_q, irq_d;

  irqc_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  irqc_sense #(.LINES(LINES), .EDGE_SEL(EDGE_SEL)) u_sense (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .line_i (irq_in),
    .req_o  (req)
  );

  assign mask_we = reg_we && (reg_sel == SEL_MASK);
  assign pend_we = reg_we && (reg_sel == SEL_PEND);

  irqc_pending #(.LINES(LINES), .ACK_MODE(ACK_MODE)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_i      (req),
    .ack_we_i   (pend_we),
    .ack_data_i (reg_wdata),
    .pend_o     (pend)
  );

  always_comb begin
    mask_d = mask_q;
    if (mask_we) begin
      mask_d = reg_wdata;
    end
    irq_d = |(pend & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_MASK: reg_rdata = mask_q;
      default:  reg_rdata = pend;
    endcase
  end

  assign core_irq = irq_q;

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    !mask_we |=> $stable(mask_q)); // R10

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n_s)
    mask_we |=> (reg_rdata == $past(reg_wdata) || reg_sel != SEL_MASK)); // R7

  AST_IRQ_FIRE: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((pend & mask_q) != '0) |=> core_irq); // R8

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((pend & mask_q) == '0) |=> !core_irq); // R8

endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
  import irqc_pkg::*;

  localparam logic [31:0] EDGES = 32'h0000_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_in;
  logic        reg_sel;
  logic        reg_we;
  logic [31:0] wdata_a, wdata_b;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, irq_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_ctrl #(.LINES(32), .EDGE_SEL(EDGES), .ACK_MODE(ACK_WRITE_ONE)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_sel(reg_sel),
    .reg_we(reg_we), .reg_wdata(wdata_a), .reg_rdata(rdata_a), .core_irq(irq_a)
  );

  irq_ctrl #(.LINES(32), .EDGE_SEL(EDGES), .ACK_MODE(ACK_WRITE_ZERO)) uut_wz (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_sel(reg_sel),
    .reg_we(reg_we), .reg_wdata(wdata_b), .reg_rdata(rdata_b), .core_irq(irq_b)
  );

  // reference model built from the requirements
  logic [31:0] m_prev, m_mask, m_pa, m_pb, m_req, m_ca, m_cb;
  logic        m_ia, m_ib;

  always_comb begin
    m_req = (irq_in & ~m_prev & EDGES) | (irq_in & ~EDGES);
    m_ca  = (reg_we && reg_sel) ? wdata_a  : 32'h0;
    m_cb  = (reg_we && reg_sel) ? ~wdata_b : 32'h0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev <= '0; m_mask <= '0; m_pa <= '0; m_pb <= '0;
      m_ia <= 1'b0; m_ib <= 1'b0;
    end else begin
      m_ia   <= |(m_pa & m_mask);
      m_ib   <= |(m_pb & m_mask);
      m_pa   <= (m_pa & ~m_ca) | m_req;
      m_pb   <= (m_pb & ~m_cb) | m_req;
      if (reg_we && !reg_sel) m_mask <= wdata_a;
      m_prev <= irq_in;
    end
  end

  function automatic logic [31:0] model_read(input logic sel, input logic [31:0] p);
    return sel ? p : m_mask;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic [31:0] lines, input logic we, input logic sel,
                      input logic [31:0] da, input logic [31:0] db);
    @(negedge clk);
    irq_in = lines; reg_we = we; reg_sel = sel; wdata_a = da; wdata_b = db;
    #1;
    chk(sel ? "R9 model pend a" : "R7 model mask a", rdata_a, model_read(sel, m_pa));
    chk(sel ? "R9 model pend b" : "R7 model mask b", rdata_b, model_read(sel, m_pb));
    chk("R8 model irq a", {31'b0, irq_a}, {31'b0, m_ia});
    chk("R8 model irq b", {31'b0, irq_b}, {31'b0, m_ib});
  endtask

  task automatic rd(input logic sel, input logic [31:0] ea, input logic [31:0] eb,
                    input string tag);
    @(negedge clk);
    reg_we = 1'b0; reg_sel = sel;
    #1;
    chk(tag, rdata_a, ea);
    chk(tag, rdata_b, eb);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; irq_in = '0; reg_sel = 1'b0; reg_we = 1'b0;
    wdata_a = '0; wdata_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) tick('0, 1'b0, 1'b0, '0, '0);

    // R1 reset state
    rd(SEL_MASK, 32'h0, 32'h0, "R1 mask");
    rd(SEL_PEND, 32'h0, 32'h0, "R1 pend");
    chk("R1 irq", {30'b0, irq_a, irq_b}, 32'h0);

    // R7 / R10 mask write
    tick('0, 1'b1, SEL_MASK, 32'h0001_0021, 32'h0001_0021);
    rd(SEL_MASK, 32'h0001_0021, 32'h0001_0021, "R7 mask readback");
    rd(SEL_PEND, 32'h0, 32'h0, "R10 pend untouched by mask write");

    // R2 edge line 0 and R8 timing
    tick(32'h1, 1'b0, SEL_PEND, '0, '0);
    rd(SEL_PEND, 32'h1, 32'h1, "R2 edge set");
    chk("R8 irq not yet", {30'b0, irq_a, irq_b}, 32'h0);
    rd(SEL_PEND, 32'h1, 32'h1, "R2 edge held");
    chk("R8 irq raised", {30'b0, irq_a, irq_b}, 32'h3);

    // R4 / R5 acknowledge while the edge line stays high
    tick(32'h1, 1'b1, SEL_PEND, 32'h1, ~32'h1);
    rd(SEL_PEND, 32'h0, 32'h0, "R4 R5 ack clears");
    rd(SEL_PEND, 32'h0, 32'h0, "R2 high line no re-set");

    // R3 level line latch
    tick(32'h0001_0000, 1'b0, SEL_PEND, '0, '0);
    tick(32'h0, 1'b0, SEL_PEND, '0, '0);
    rd(SEL_PEND, 32'h0001_0000, 32'h0001_0000, "R3 level latched");
    rd(SEL_PEND, 32'h0001_0000, 32'h0001_0000, "R3 level still latched");

    // R4 / R5 non-clearing write values
    tick(32'h0, 1'b1, SEL_PEND, 32'h0, 32'hFFFF_FFFF);
    rd(SEL_PEND, 32'h0001_0000, 32'h0001_0000, "R4 R5 no-effect write");

    // R6 request wins over a simultaneous acknowledge
    tick(32'h0001_0000, 1'b1, SEL_PEND, 32'h0001_0000, ~32'h0001_0000);
    tick(32'h0, 1'b0, SEL_PEND, '0, '0);
    rd(SEL_PEND, 32'h0001_0000, 32'h0001_0000, "R6 request wins");
    tick(32'h0, 1'b1, SEL_PEND, 32'h0001_0000, ~32'h0001_0000);
    rd(SEL_PEND, 32'h0, 32'h0, "R4 R5 level ack");

    // R7 / R8 masked line still visible but silent
    tick(32'h8, 1'b0, SEL_PEND, '0, '0);
    tick(32'h0, 1'b0, SEL_PEND, '0, '0);
    rd(SEL_PEND, 32'h8, 32'h8, "R7 raw pend ignores mask");
    chk("R8 masked line silent", {30'b0, irq_a, irq_b}, 32'h0);
    tick(32'h0, 1'b1, SEL_PEND, 32'h8, ~32'h8);
    rd(SEL_MASK, 32'h0001_0021, 32'h0001_0021, "R10 mask untouched by ack");

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] ln, da, db;
      logic we, sel;
      ln  = $urandom & $urandom & $urandom;
      we  = ($urandom % 4) == 0;
      sel = ($urandom % 3) != 0;
      da  = sel ? ($urandom & $urandom) : $urandom;
      db  = sel ? ~($urandom & $urandom) : da;
      if (!sel) db = da;
      tick(ln, we, sel, da, db);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule